// File: doc/BRIEF.md
# Parallel LCD Bus Strobe Sequencer

This block is the bus master for an 8080-style parallel LCD interface. It accepts one transfer request at a time, either a command write, a data write or a data read, each carrying one bus word. It then drives chip-select, write-enable, read-enable and the command/data select line. Each strobe edge is placed at a tick offset that software programs. A tick is either one interface clock or two interface clocks, chosen by a single granularity input.

The edge offsets come from two packed timing words and a separate read access time. Every strobe gets its own on-tick and off-tick. The write and read cycle lengths and a minimum chip-select width come from the second word. The block widens the chip-select window so that it always covers the write and read strobes and the minimum pulse width. It raises a configuration-error flag when the other ordering rules are broken. For a read, the value on the input bus is captured at the end of the access-time tick. It is returned on a one-cycle response strobe when the access retires.

The controller has two states. ST_IDLE is the only state with `req_ready` high. The ACCEPT transition moves it from ST_IDLE to ST_XFER when `req_valid` is high, and it latches the request kind and word. In ST_XFER a tick counter starts at 0 and advances once per tick. The RETIRE transition moves it back to ST_IDLE on the final tick of the access. A held request is therefore accepted on the clock edge right after `busy` falls.

Top module: `lcd_bus_master`

## Requirements
- R1: While reset is low and after it is released with no request, the block is idle. At default polarities `lcd_cs`, `lcd_we`, `lcd_re` and `lcd_a0` are 1. `busy`, `lcd_oe`, `rsp_valid` and `rsp_data` are 0, and `req_ready` is 1.
- R2: `req_ready` is high exactly when the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `busy` is high from the next clock. A request presented while `busy` is high is not taken until the current access retires.
- R3: `req_kind` encodes the access: 0 is a command write, 1 is a data write, and 2 or 3 (bit 1 set) is a data read. Tick t is counted from 0 at the first clock after acceptance. Chip-select is active for cs_on ≤ t < cs_end. On writes, write-enable is active for we_on ≤ t < we_off.
- R4: On reads, read-enable is active for re_on ≤ t < re_off, and write-enable stays inactive.
- R5: The access lasts L ticks, where L = max(cycle, cs_end, 1). The cycle is the write cycle time for writes and the read cycle time for reads. `busy` is high for exactly L × divide clocks.
- R6: cs_end = max(cs_off, we_off, re_off, cs_on + cs_min_width). Chip-select is never released before the write and read strobes end or before the minimum width has passed.
- R7: With `tick_div2` = 0 each tick lasts one clock. With `tick_div2` = 1 each tick lasts two clocks.
- R8: `cfg_err` is 1 exactly when any of these holds: we_off ≤ we_on, re_off ≤ re_on, read cycle < re_off, write cycle < we_off, cs_off ≤ cs_on, or access time ≤ re_on. A chip-select off time below the write or read off time alone does not raise it.
- R9: Each strobe is active-low when its invert input is 0 and active-high when it is 1. `lcd_a0` is logic 0 during a command write and logic 1 otherwise, including idle, and the result is XORed with `inv_a0`.
- R10: During a write access `lcd_oe` is 1 and `lcd_dout` carries the accepted word. `lcd_oe` is 0 during reads and when idle.
- R11: Field positions: `edge_word` holds cs_on [3:0], cs_off [9:4], we_on [13:10], we_off [19:14], re_on [23:20] and re_off [29:24]. `cyc_word` holds the write cycle [5:0], the read cycle [11:6] and cs_min_width [17:12].
- R12: A read captures `lcd_din` on the last clock edge of tick `acc_time`. That value appears on `rsp_data` with `rsp_valid` high for the one clock after the access retires. `rsp_data` then holds until a later read captures again, and write accesses leave it unchanged.
- R13: Back-to-back: if `req_valid` stays high, the next access is accepted on the edge right after `busy` falls, and its tick counter restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_word | input | 30 | Packed strobe on/off tick offsets |
| cyc_word | input | 18 | Packed write cycle, read cycle, minimum chip-select width |
| acc_time | input | 6 | Read capture tick |
| tick_div2 | input | 1 | Tick granularity: 0 = one clock, 1 = two clocks |
| inv_cs | input | 1 | Chip-select active-high when 1 |
| inv_we | input | 1 | Write-enable active-high when 1 |
| inv_re | input | 1 | Read-enable active-high when 1 |
| inv_a0 | input | 1 | Inverts the command/data select level |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this clock |
| req_kind | input | 2 | 0 command write, 1 data write, 2/3 data read |
| req_word | input | 16 | Word to drive on writes |
| rsp_valid | output | 1 | One-clock strobe after a read retires |
| rsp_data | output | 16 | Last captured read value |
| busy | output | 1 | An access is in progress |
| cfg_err | output | 1 | Timing words break an ordering rule |
| lcd_cs | output | 1 | Chip-select pin level |
| lcd_we | output | 1 | Write-enable pin level |
| lcd_re | output | 1 | Read-enable pin level |
| lcd_a0 | output | 1 | Command/data select pin level |
| lcd_dout | output | 16 | Write data bus |
| lcd_oe | output | 1 | Write data bus drive enable |
| lcd_din | input | 16 | Read data bus |

## Verification
The assertions assume that the timing words, the granularity bit and the invert inputs stay constant while `busy` is high. Under that assumption the tick counter stays below the access length, the tick strobe alternates in divide-by-two mode, and the read register changes only inside a read access. The stimulus obeys this assumption: it reprograms the configuration only between accesses, while the block is idle. It also varies `lcd_din` on every clock during reads, so a capture on the wrong edge shows up as a different value.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } lbm_state_e;

    localparam logic [1:0] KIND_CMD = 2'd0;

endpackage

// File: rtl/lbm_tick_gen.sv
module lbm_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div2,
    output logic tick
);

    logic phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (!run || !div2) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign tick = run && (!div2 || phase_q);

    // R7: in divide-by-two mode a tick is never followed by another tick
    a_r7_tick_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div2 && tick) |=> !tick);

endmodule

// File: rtl/lbm_timing_check.sv
module lbm_timing_check #(
    parameter int ON_W  = 4,
    parameter int OFF_W = 6,
    parameter int CNT_W = 7
) (
    input  logic [3*(ON_W+OFF_W)-1:0] edge_word,
    input  logic [3*OFF_W-1:0]        cyc_word,
    input  logic [OFF_W-1:0]          acc_time,
    output logic [CNT_W-1:0]          cs_on,
    output logic [CNT_W-1:0]          cs_end,
    output logic [CNT_W-1:0]          we_on,
    output logic [CNT_W-1:0]          we_off,
    output logic [CNT_W-1:0]          re_on,
    output logic [CNT_W-1:0]          re_off,
    output logic [CNT_W-1:0]          len_wr,
    output logic [CNT_W-1:0]          len_rd,
    output logic [CNT_W-1:0]          acc_x,
    output logic                      cfg_err
);

    localparam int PAIR_W = ON_W + OFF_W;
    localparam int NSTB   = 3;

    logic [CNT_W-1:0] raw_on  [NSTB];
    logic [CNT_W-1:0] raw_off [NSTB];
    logic [CNT_W-1:0] cyc_f   [NSTB];
    logic [CNT_W-1:0] cs_min;

    for (genvar i = 0; i < NSTB; i++) begin : g_unpack
        assign raw_on[i]  = CNT_W'(edge_word[i*PAIR_W +: ON_W]);
        assign raw_off[i] = CNT_W'(edge_word[i*PAIR_W + ON_W +: OFF_W]);
        assign cyc_f[i]   = CNT_W'(cyc_word[i*OFF_W +: OFF_W]);
    end

    assign acc_x  = CNT_W'(acc_time);
    assign cs_on  = raw_on[0];
    assign we_on  = raw_on[1];
    assign we_off = raw_off[1];
    assign re_on  = raw_on[2];
    assign re_off = raw_off[2];
    assign cs_min = raw_on[0] + cyc_f[2];

    always_comb begin
        cs_end = raw_off[0];
        if (raw_off[1] > cs_end) cs_end = raw_off[1];
        if (raw_off[2] > cs_end) cs_end = raw_off[2];
        if (cs_min > cs_end)     cs_end = cs_min;
        len_wr = (cyc_f[0] > cs_end) ? cyc_f[0] : cs_end;
        len_rd = (cyc_f[1] > cs_end) ? cyc_f[1] : cs_end;
        if (len_wr == '0) len_wr = CNT_W'(1);
        if (len_rd == '0) len_rd = CNT_W'(1);
        cfg_err = (raw_off[1] <= raw_on[1]) || (raw_off[2] <= raw_on[2])
               || (cyc_f[1] < raw_off[2])   || (cyc_f[0] < raw_off[1])
               || (raw_off[0] <= raw_on[0]) || (acc_x <= raw_on[2]);
    end

endmodule

// File: rtl/lcd_bus_master.sv
module lcd_bus_master
    import lbm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ON_W   = 4,
    parameter int OFF_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [3*(ON_W+OFF_W)-1:0] edge_word,
    input  logic [3*OFF_W-1:0]        cyc_word,
    input  logic [OFF_W-1:0]          acc_time,
    input  logic                      tick_div2,
    input  logic                      inv_cs,
    input  logic                      inv_we,
    input  logic                      inv_re,
    input  logic                      inv_a0,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [1:0]                req_kind,
    input  logic [DATA_W-1:0]         req_word,
    output logic                      rsp_valid,
    output logic [DATA_W-1:0]         rsp_data,
    output logic                      busy,
    output logic                      cfg_err,
    output logic                      lcd_cs,
    output logic                      lcd_we,
    output logic                      lcd_re,
    output logic                      lcd_a0,
    output logic [DATA_W-1:0]         lcd_dout,
    output logic                      lcd_oe,
    input  logic [DATA_W-1:0]         lcd_din
);

    localparam int CNT_W = ((ON_W > OFF_W) ? ON_W : OFF_W) + 1;

    lbm_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              rd_q, cmd_q, rvld_q;
    logic [DATA_W-1:0] word_q, rdat_q;
    logic              xfer, tick, last_tick;
    logic              cs_act, we_act, re_act;
    logic [CNT_W-1:0]  cs_on, cs_end, we_on, we_off, re_on, re_off;
    logic [CNT_W-1:0]  len_wr, len_rd, len_cur, acc_x;

    lbm_timing_check #(.ON_W(ON_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_tcheck (
        .edge_word (edge_word),
        .cyc_word  (cyc_word),
        .acc_time  (acc_time),
        .cs_on     (cs_on),
        .cs_end    (cs_end),
        .we_on     (we_on),
        .we_off    (we_off),
        .re_on     (re_on),
        .re_off    (re_off),
        .len_wr    (len_wr),
        .len_rd    (len_rd),
        .acc_x     (acc_x),
        .cfg_err   (cfg_err)
    );

    assign xfer = (state_q == ST_XFER);

    lbm_tick_gen u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (xfer),
        .div2  (tick_div2),
        .tick  (tick)
    );

    assign len_cur   = rd_q ? len_rd : len_wr;
    assign last_tick = xfer && tick && (cnt_q == len_cur - CNT_W'(1));

    // next-state logic: ACCEPT and RETIRE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_XFER;
            ST_XFER: if (last_tick) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // tick counter, request latch and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rd_q   <= 1'b0;
            cmd_q  <= 1'b0;
            word_q <= '0;
            rdat_q <= '0;
            rvld_q <= 1'b0;
        end else begin
            rvld_q <= 1'b0;
            if (!xfer) begin
                cnt_q <= '0;
                if (req_valid) begin
                    rd_q   <= req_kind[1];
                    cmd_q  <= (req_kind == KIND_CMD);
                    word_q <= req_word;
                end
            end else begin
                if (tick) cnt_q <= cnt_q + CNT_W'(1);
                if (rd_q && tick && (cnt_q == acc_x)) rdat_q <= lcd_din;
                if (rd_q && last_tick) rvld_q <= 1'b1;
            end
        end
    end

    // pin outputs
    always_comb begin
        cs_act    = xfer && (cnt_q >= cs_on) && (cnt_q < cs_end);
        we_act    = xfer && !rd_q && (cnt_q >= we_on) && (cnt_q < we_off);
        re_act    = xfer && rd_q && (cnt_q >= re_on) && (cnt_q < re_off);
        lcd_cs    = inv_cs ? cs_act : ~cs_act;
        lcd_we    = inv_we ? we_act : ~we_act;
        lcd_re    = inv_re ? re_act : ~re_act;
        lcd_a0    = ~(xfer && cmd_q) ^ inv_a0;
        lcd_oe    = xfer && !rd_q;
        lcd_dout  = word_q;
        req_ready = !xfer;
        busy      = xfer;
        rsp_valid = rvld_q;
        rsp_data  = rdat_q;
    end

    // R2: an accepted request makes the block busy on the next clock
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    // R5: the tick counter stays inside the access length
    a_r5_cnt_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q < len_cur));

    // R4: write-enable pin stays at its idle level whenever the data bus is not driven
    a_r4_we_idle_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_oe |-> (lcd_we == !inv_we));

    // R10: the data bus is only driven inside an access
    a_r10_oe_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_oe |-> busy);

    // R12: captured read data only moves during a read access
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer && rd_q) |=> $stable(rdat_q));

    // R8: a clean configuration always gives a non-empty chip-select window
    a_r8_clean_window: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_err) |-> (cs_end > cs_on));

endmodule

// File: tb/lcd_bus_master_test.sv
`timescale 1ns/1ps
module lcd_bus_master_test;

    typedef struct packed {
        logic [3:0]  cson;
        logic [5:0]  csoff;
        logic [3:0]  weon;
        logic [5:0]  weoff;
        logic [3:0]  reon;
        logic [5:0]  reoff;
        logic [5:0]  wcyc;
        logic [5:0]  rcyc;
        logic [5:0]  cspw;
        logic [5:0]  acc;
        logic        div2;
        logic [1:0]  kind;
        logic [3:0]  pol;   // {a0, re, we, cs}
        logic [15:0] word;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t TBL [NVEC] = '{
        '{4'd1, 6'd5, 4'd2, 6'd4, 4'd1, 6'd3, 6'd6, 6'd5, 6'd2, 6'd2, 1'b0, 2'd0, 4'b0000, 16'h1234},
        '{4'd0, 6'd3, 4'd1, 6'd3, 4'd0, 6'd2, 6'd4, 6'd4, 6'd1, 6'd1, 1'b1, 2'd1, 4'b0000, 16'hBEEF},
        '{4'd0, 6'd6, 4'd1, 6'd2, 4'd1, 6'd5, 6'd3, 6'd7, 6'd3, 6'd3, 1'b0, 2'd2, 4'b0000, 16'h0000},
        '{4'd1, 6'd4, 4'd0, 6'd1, 4'd1, 6'd4, 6'd2, 6'd5, 6'd2, 6'd2, 1'b1, 2'd3, 4'b1111, 16'h0000},
        '{4'd0, 6'd2, 4'd1, 6'd5, 4'd0, 6'd1, 6'd5, 6'd2, 6'd1, 6'd1, 1'b0, 2'd0, 4'b0101, 16'h00A5},
        '{4'd2, 6'd4, 4'd2, 6'd3, 4'd0, 6'd1, 6'd4, 6'd4, 6'd5, 6'd1, 1'b0, 2'd1, 4'b1010, 16'h5A5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] edge_word = '0;
    logic [17:0] cyc_word = '0;
    logic [5:0]  acc_time = '0;
    logic        tick_div2 = 1'b0;
    logic        inv_cs = 1'b0, inv_we = 1'b0, inv_re = 1'b0, inv_a0 = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_word = '0;
    logic [15:0] lcd_din = '0;
    logic        req_ready, rsp_valid, busy, cfg_err;
    logic [15:0] rsp_data, lcd_dout;
    logic        lcd_cs, lcd_we, lcd_re, lcd_a0, lcd_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] last_rd = '0;

    always #2.5 clk = ~clk;

    lcd_bus_master uut (
        .clk(clk), .rst_n(rst_n), .edge_word(edge_word), .cyc_word(cyc_word),
        .acc_time(acc_time), .tick_div2(tick_div2), .inv_cs(inv_cs), .inv_we(inv_we),
        .inv_re(inv_re), .inv_a0(inv_a0), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_word(req_word), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .busy(busy), .cfg_err(cfg_err), .lcd_cs(lcd_cs), .lcd_we(lcd_we), .lcd_re(lcd_re),
        .lcd_a0(lcd_a0), .lcd_dout(lcd_dout), .lcd_oe(lcd_oe), .lcd_din(lcd_din)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // R6: chip-select end tick
    function automatic int exp_csend(input vec_t v);
        return mx(mx(int'(v.csoff), int'(v.weoff)), mx(int'(v.reoff), int'(v.cson) + int'(v.cspw)));
    endfunction

    // R5: access length in ticks
    function automatic int exp_len(input vec_t v);
        int c = v.kind[1] ? int'(v.rcyc) : int'(v.wcyc);
        return mx(mx(c, exp_csend(v)), 1);
    endfunction

    task automatic apply_cfg(input vec_t v);
        // R11 field layout
        edge_word = {v.reoff, v.reon, v.weoff, v.weon, v.csoff, v.cson};
        cyc_word  = {v.cspw, v.rcyc, v.wcyc};
        acc_time  = v.acc;
        tick_div2 = v.div2;
        {inv_a0, inv_re, inv_we, inv_cs} = v.pol;
    endtask

    function automatic logic pin(input logic act, input logic inv);
        return inv ? act : ~act;
    endfunction

    task automatic check_clock(input vec_t v, input int k);
        int  dv = v.div2 ? 2 : 1;
        int  t = k / dv;
        bit  rd = v.kind[1];
        logic cs_a = (t >= int'(v.cson)) && (t < exp_csend(v));
        logic we_a = !rd && (t >= int'(v.weon)) && (t < int'(v.weoff));
        logic re_a = rd && (t >= int'(v.reon)) && (t < int'(v.reoff));
        chk("R2 busy during access", busy, 1);
        chk("R2 ready low while busy", req_ready, 0);
        chk("R3/R6/R7 chip-select", lcd_cs, pin(cs_a, v.pol[0]));
        chk("R3/R7 write-enable", lcd_we, pin(we_a, v.pol[1]));
        chk("R4 read-enable", lcd_re, pin(re_a, v.pol[2]));
        chk("R9 command/data select", lcd_a0, ((v.kind == 2'd0) ? 1'b0 : 1'b1) ^ v.pol[3]);
        chk("R10 bus drive enable", lcd_oe, !rd);
        if (!rd) chk("R10 write data", lcd_dout, v.word);
    endtask

    // one full access; returns with the clock at the first idle negedge
    task automatic run_access(input vec_t v, input bit keep_valid);
        int dv = v.div2 ? 2 : 1;
        int n = exp_len(v) * dv;
        bit rd = v.kind[1];
        @(negedge clk);
        apply_cfg(v);
        req_kind  = v.kind;
        req_word  = v.word;
        req_valid = 1'b1;
        #0.5;
        chk("R8 legal table config", cfg_err, 0);
        @(negedge clk);
        if (!keep_valid) req_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            check_clock(v, k);
            lcd_din = 16'hA000 + 16'(k);
        end
        @(negedge clk);
        chk("R5 busy drops after L*div clocks", busy, 0);
        chk("R2 ready back after access", req_ready, 1);
        chk("R12 response strobe", rsp_valid, rd);
        if (rd) last_rd = 16'hA000 + 16'(int'(v.acc) * dv + dv - 1);
        chk("R12 response data", rsp_data, last_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        vec_t bad;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        chk("R1 cs idle in reset", lcd_cs, 1);
        chk("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1 after release
        chk("R1 cs idle", lcd_cs, 1);
        chk("R1 we idle", lcd_we, 1);
        chk("R1 re idle", lcd_re, 1);
        chk("R1 a0 idle", lcd_a0, 1);
        chk("R1 busy", busy, 0);
        chk("R1 ready", req_ready, 1);
        chk("R1 oe", lcd_oe, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rsp_data", rsp_data, 0);

        // table walk: R3 R4 R5 R6 R7 R9 R10 R11 R12
        for (int i = 0; i < NVEC; i++) run_access(TBL[i], 1'b0);

        // R8: error conditions
        bad = TBL[0];
        bad.weoff = 6'd2;
        apply_cfg(bad);
        #0.5 chk("R8 we_off equal to we_on", cfg_err, 1);
        bad = TBL[2];
        bad.acc = 6'd1;
        apply_cfg(bad);
        #0.5 chk("R8 access time equal to re_on", cfg_err, 1);
        bad = TBL[0];
        bad.csoff = 6'd1;
        apply_cfg(bad);
        #0.5 chk("R8 cs_off equal to cs_on", cfg_err, 1);
        apply_cfg(TBL[4]);
        #0.5 chk("R8 clamped cs_off alone is no error", cfg_err, 0);

        // R13: back-to-back with valid held; the second access restarts at tick 0
        run_access(TBL[0], 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R13 second access accepted at once", busy, 1);
        chk("R13 counter restarted, cs idle at tick 0", lcd_cs, 1);
        @(negedge clk);
        chk("R13 cs active at tick 1", lcd_cs, 0);
        repeat (4) @(negedge clk);
        chk("R13 second access still busy at tick 5", busy, 1);
        @(negedge clk);
        chk("R13 second access retired", busy, 0);
        chk("R12 write keeps read data", rsp_data, last_rd);

        // R2: a request while busy is not taken early
        run_access(TBL[2], 1'b0);
        @(negedge clk);
        req_kind = 2'd1; req_word = 16'h7777; req_valid = 1'b1;
        @(negedge clk);
        chk("R2 accepted write", busy, 1);
        req_kind = 2'd2;
        @(negedge clk);
        chk("R2 kind change while busy ignored", lcd_oe, 1);
        chk("R2 word held while busy", lcd_dout, 16'h7777);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk("R2 access retired", busy, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule